// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Flagged Receive Queue

This block recovers bytes from an asynchronous serial line that idles high. A frame opens with a low start bit. Eight data bits follow, least significant bit first. An optional parity bit comes next, and a single high stop bit closes the frame. Timing comes from a sample-enable pulse at OVS times the bit rate, so the baud generator lives outside the block. A falling edge counts as a start bit only if the line is still low at the middle of the bit. Every later bit is sampled once at its centre.

Each finished frame goes into a receive queue together with its own framing and parity error tags. A frame with an error is stored like any other, and the receiver carries on with the next frame.

Five sticky flags summarise receive status: queue at trigger level, receive error, break, data ready, and overrun. The first four each have an enable bit, and their enabled OR drives one interrupt output. A host pops bytes from the queue head. It clears a flag by first strobing a status read and then writing a clear mask.

Top module: `async_rx_fifo`

## Requirements
- R1: With parity disabled, a frame of start bit, eight data bits (bit 0 first) and a high stop bit stores exactly that byte, with both error tags clear.
- R2: A low pulse on the line that ends before the middle of the start bit is discarded: nothing is stored and the next real frame is received normally.
- R3: With parity enabled, the bit after data bit 7 is the parity bit. Even mode (par_odd=0) expects the XOR of the data bits. Odd mode expects its inverse. A mismatch stores the byte with rd_perr=1, and a low stop bit stores the byte with rd_ferr=1.
- R4: A framing or parity error does not stop reception: the next well-formed frame is stored with clean tags.
- R5: The queue returns bytes in arrival order. fifo_count never exceeds DEPTH, rd_valid is high exactly when fifo_count is nonzero, and a pop removes the head entry.
- R6: A frame completed while the queue holds DEPTH entries is dropped, the stored entries are unchanged, and overrun flag bit 4 is set.
- R7: Flag bit 0 (level) sets whenever fifo_count is at least trig_lvl. A trig_lvl of 0 acts as 1.
- R8: A flag bit is cleared by a flag_clr bit only if a flag_rd strobe earlier saw that bit as 1. A clear without that read has no effect, and a set condition in the same cycle wins over the clear.
- R9: Storing an entry with a framing or parity error sets flag bit 1 (error).
- R10: A line held low through the stop-bit position of a frame with all-zero data and parity sets flag bit 2 (break) and stores one entry with data 0 and rd_ferr=1. No further frame starts until the line returns high.
- R11: Flag bit 3 (data ready) sets once the line has been idle for IDLE_BITS bit times after the last stop bit, while 0 < fifo_count < effective trigger level.
- R12: irq is the OR of flag bits 3..0 each ANDed with the ien bit of the same index. Overrun (bit 4) never drives irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| samp_en | input | 1 | Sample enable at OVS times the bit rate |
| rxd | input | 1 | Serial receive line, idles high |
| par_en | input | 1 | Parity bit present in the frame |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| trig_lvl | input | $clog2(DEPTH+1) | Queue fill level that sets the level flag |
| ien | input | 4 | Interrupt enables for flag bits 3..0 |
| rd_pop | input | 1 | Remove the head entry |
| rd_data | output | 8 | Head entry data byte |
| rd_ferr | output | 1 | Head entry framing error tag |
| rd_perr | output | 1 | Head entry parity error tag |
| rd_valid | output | 1 | Queue not empty |
| fifo_count | output | $clog2(DEPTH+1) | Number of stored entries |
| flag_rd | input | 1 | Status read strobe; arms the clear of every flag seen as 1 |
| flag_clr | input | 5 | Clear mask (0 level, 1 error, 2 break, 3 data ready, 4 overrun) |
| flags | output | 5 | Sticky status flags, same bit order as flag_clr |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with DEPTH=4, OVS=8 and IDLE_BITS=2, and pulses samp_en on every second clock. With these values all 256 byte values fit into one sweep. Overrun appears on the fifth frame, and every trigger level from 1 to DEPTH can be swept frame by frame. The data-ready idle window also expires within a few bit times, so the bench can observe it both before and after it runs out.

// File: rtl/arx_pkg.sv
package arx_pkg;
    localparam int DW    = 8;
    localparam int NFLAG = 5;

    // flag bit positions
    localparam int F_LVL = 0;
    localparam int F_ERR = 1;
    localparam int F_BRK = 2;
    localparam int F_RDY = 3;
    localparam int F_OVR = 4;

    typedef struct packed {
        logic [DW-1:0] data;
        logic          ferr;
        logic          perr;
    } rx_entry_t;

    typedef enum logic [2:0] {
        S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_MARK
    } rx_state_t;

    function automatic logic parity_bit(input logic [DW-1:0] d, input logic odd);
        return (^d) ^ odd;
    endfunction
endpackage

// File: rtl/arx_framer.sv
module arx_framer
    import arx_pkg::*;
#(
    parameter int OVS       = 16,
    parameter int IDLE_BITS = 15
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      rx,
    input  logic      par_en,
    input  logic      par_odd,
    output logic      fr_valid,
    output rx_entry_t fr_entry,
    output logic      fr_brk,
    output logic      line_idle
);
    localparam int CW         = $clog2(OVS);
    localparam int BW         = $clog2(DW);
    localparam int IDLE_TICKS = OVS * IDLE_BITS;
    localparam int IW         = $clog2(IDLE_TICKS + 1);
    localparam logic [CW-1:0] C_MID  = CW'(OVS / 2 - 1);
    localparam logic [CW-1:0] C_END  = CW'(OVS - 1);
    localparam logic [BW-1:0] B_LAST = BW'(DW - 1);
    localparam logic [IW-1:0] I_FULL = IW'(IDLE_TICKS);

    rx_state_t     st;
    logic [CW-1:0] cnt;
    logic [BW-1:0] bidx;
    logic [DW-1:0] shreg;
    logic          pbit;
    logic [IW-1:0] idle_cnt;
    logic          at_end;

    assign at_end    = (cnt == C_END);
    assign line_idle = (st == S_IDLE) && (idle_cnt == I_FULL);

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= S_IDLE;
            cnt      <= '0;
            bidx     <= '0;
            shreg    <= '0;
            pbit     <= 1'b0;
            idle_cnt <= '0;
            fr_valid <= 1'b0;
            fr_brk   <= 1'b0;
            fr_entry <= '0;
        end else begin
            fr_valid <= 1'b0;
            fr_brk   <= 1'b0;
            if (tick) begin
                unique case (st)
                    S_IDLE: begin
                        cnt <= '0;
                        if (!rx) st <= S_START;
                        else if (idle_cnt != I_FULL) idle_cnt <= idle_cnt + 1'b1;
                    end
                    S_START: begin  // R2: confirm low level at mid start bit
                        if (cnt == C_MID) begin
                            cnt <= '0;
                            if (rx) st <= S_IDLE;
                            else begin
                                st       <= S_DATA;
                                bidx     <= '0;
                                idle_cnt <= '0;
                            end
                        end else cnt <= cnt + 1'b1;
                    end
                    S_DATA: begin  // R1: bit 0 first
                        if (at_end) begin
                            cnt   <= '0;
                            shreg <= {rx, shreg[DW-1:1]};
                            if (bidx == B_LAST) st <= par_en ? S_PAR : S_STOP;
                            else bidx <= bidx + 1'b1;
                        end else cnt <= cnt + 1'b1;
                    end
                    S_PAR: begin
                        if (at_end) begin
                            cnt  <= '0;
                            pbit <= rx;
                            st   <= S_STOP;
                        end else cnt <= cnt + 1'b1;
                    end
                    S_STOP: begin  // R3 R10: checks done before the byte is handed on
                        if (at_end) begin
                            cnt           <= '0;
                            fr_valid      <= 1'b1;
                            fr_entry.data <= shreg;
                            fr_entry.ferr <= !rx;
                            fr_entry.perr <= par_en && (pbit != parity_bit(shreg, par_odd));
                            fr_brk        <= !rx && (shreg == '0) && (!par_en || !pbit);
                            st            <= rx ? S_IDLE : S_MARK;
                        end else cnt <= cnt + 1'b1;
                    end
                    S_MARK: begin  // R10: wait for the line to return high
                        if (rx) st <= S_IDLE;
                    end
                    default: st <= S_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/arx_fifo.sv
module arx_fifo
    import arx_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         push,
    input  rx_entry_t                    push_entry,
    input  logic                         pop,
    output rx_entry_t                    head,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         ovr_pulse
);
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNTW = $clog2(DEPTH + 1);
    localparam logic [CNTW-1:0] C_FULL = CNTW'(DEPTH);
    localparam logic [AW-1:0]   A_LAST = AW'(DEPTH - 1);

    rx_entry_t     mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          is_full, is_empty, do_push, do_pop;

    assign is_full   = (count == C_FULL);
    assign is_empty  = (count == '0);
    assign do_push   = push && !is_full;   // R6: drop when full
    assign do_pop    = pop && !is_empty;
    assign ovr_pulse = push && is_full;
    assign head      = mem[rp];

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (do_push) begin
                mem[wp] <= push_entry;
                wp      <= (wp == A_LAST) ? '0 : wp + 1'b1;
            end
            if (do_pop) rp <= (rp == A_LAST) ? '0 : rp + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/arx_flags.sv
module arx_flags
    import arx_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [$clog2(DEPTH+1)-1:0] count,
    input  logic [$clog2(DEPTH+1)-1:0] trig_lvl,
    input  logic                       fr_valid,
    input  logic                       fr_bad,
    input  logic                       fr_brk,
    input  logic                       ovr_pulse,
    input  logic                       line_idle,
    input  logic                       flag_rd,
    input  logic [NFLAG-1:0]           flag_clr,
    input  logic [3:0]                 ien,
    output logic [NFLAG-1:0]           flags,
    output logic                       irq
);
    logic [NFLAG-1:0] set_v, armed, clr_ok;
    logic             at_lvl;

    // R7: level 0 behaves as level 1
    assign at_lvl = (trig_lvl == '0) ? (count != '0) : (count >= trig_lvl);

    always_comb begin
        set_v        = '0;
        set_v[F_LVL] = at_lvl;
        set_v[F_ERR] = fr_valid && fr_bad;                     // R9
        set_v[F_BRK] = fr_valid && fr_brk;                     // R10
        set_v[F_RDY] = line_idle && (count != '0) && !at_lvl;  // R11
        set_v[F_OVR] = ovr_pulse;                              // R6
    end

    assign clr_ok = flag_clr & armed;  // R8

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
            armed <= '0;
        end else begin
            flags <= (flags & ~clr_ok) | set_v;
            armed <= flag_rd ? flags : (armed & ~flag_clr);
        end
    end

    assign irq = |(flags[F_RDY:F_LVL] & ien);  // R12
endmodule

// File: rtl/async_rx_fifo.sv
module async_rx_fifo
    import arx_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int OVS       = 16,
    parameter int IDLE_BITS = 15
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       samp_en,
    input  logic                       rxd,
    input  logic                       par_en,
    input  logic                       par_odd,
    input  logic [$clog2(DEPTH+1)-1:0] trig_lvl,
    input  logic [3:0]                 ien,
    input  logic                       rd_pop,
    output logic [7:0]                 rd_data,
    output logic                       rd_ferr,
    output logic                       rd_perr,
    output logic                       rd_valid,
    output logic [$clog2(DEPTH+1)-1:0] fifo_count,
    input  logic                       flag_rd,
    input  logic [4:0]                 flag_clr,
    output logic [4:0]                 flags,
    output logic                       irq
);
    logic [1:0] sync_q;
    logic       fr_valid, fr_brk, line_idle, ovr_pulse;
    rx_entry_t  fr_entry, head;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= 2'b11;
        else     sync_q <= {sync_q[0], rxd};
    end

    arx_framer #(.OVS(OVS), .IDLE_BITS(IDLE_BITS)) u_framer (
        .clk      (clk),
        .rst      (rst),
        .tick     (samp_en),
        .rx       (sync_q[1]),
        .par_en   (par_en),
        .par_odd  (par_odd),
        .fr_valid (fr_valid),
        .fr_entry (fr_entry),
        .fr_brk   (fr_brk),
        .line_idle(line_idle)
    );

    arx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (fr_valid),
        .push_entry(fr_entry),
        .pop       (rd_pop),
        .head      (head),
        .count     (fifo_count),
        .ovr_pulse (ovr_pulse)
    );

    arx_flags #(.DEPTH(DEPTH)) u_flags (
        .clk      (clk),
        .rst      (rst),
        .count    (fifo_count),
        .trig_lvl (trig_lvl),
        .fr_valid (fr_valid),
        .fr_bad   (fr_entry.ferr | fr_entry.perr),
        .fr_brk   (fr_brk),
        .ovr_pulse(ovr_pulse),
        .line_idle(line_idle),
        .flag_rd  (flag_rd),
        .flag_clr (flag_clr),
        .ien      (ien),
        .flags    (flags),
        .irq      (irq)
    );

    assign rd_valid = (fifo_count != '0);
    assign rd_data  = head.data;
    assign rd_ferr  = head.ferr;
    assign rd_perr  = head.perr;
endmodule

// File: rtl/async_rx_fifo_chk.sv
module async_rx_fifo_chk #(
    parameter int DEPTH = 16
) (
    input logic                       clk,
    input logic                       rst,
    input logic [$clog2(DEPTH+1)-1:0] trig_lvl,
    input logic [3:0]                 ien,
    input logic                       rd_pop,
    input logic [$clog2(DEPTH+1)-1:0] fifo_count,
    input logic [4:0]                 flag_clr,
    input logic [4:0]                 flags,
    input logic                       irq
);
    localparam int CNTW = $clog2(DEPTH + 1);
    logic [CNTW-1:0] trig_eff;
    assign trig_eff = (trig_lvl == '0) ? CNTW'(1) : trig_lvl;

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        fifo_count <= CNTW'(DEPTH)); // R5
    AST_POP_NO_GROW: assert property (@(posedge clk) disable iff (rst)
        (rd_pop && fifo_count != '0) |=> fifo_count <= $past(fifo_count)); // R5
    AST_LEVEL_FLAG: assert property (@(posedge clk) disable iff (rst)
        (fifo_count >= trig_eff) |=> flags[0]); // R7
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        ((rst == 1'b0) && ($past(rst) == 1'b0)) |-> ((($past(flags) & ~$past(flag_clr)) & ~flags) == 5'd0)); // R8
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
        (ien == 4'd0) |-> !irq); // R12
endmodule

bind async_rx_fifo async_rx_fifo_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .trig_lvl  (trig_lvl),
    .ien       (ien),
    .rd_pop    (rd_pop),
    .fifo_count(fifo_count),
    .flag_clr  (flag_clr),
    .flags     (flags),
    .irq       (irq)
);

// File: tb/async_rx_fifo_bench.sv
`timescale 1ns/1ps
module async_rx_fifo_bench;
    localparam int DEPTH = 4;
    localparam int OVS   = 8;
    localparam int IDLE  = 2;
    localparam int CNTW  = $clog2(DEPTH + 1);
    localparam int BITCLK = 2 * OVS;  // samp_en every second clock

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic samp_en = 1'b0;
    logic rxd = 1'b1;
    logic par_en = 1'b0, par_odd = 1'b0;
    logic [CNTW-1:0] trig_lvl = CNTW'(DEPTH);
    logic [3:0] ien = 4'd0;
    logic rd_pop = 1'b0;
    logic [7:0] rd_data;
    logic rd_ferr, rd_perr, rd_valid;
    logic [CNTW-1:0] fifo_count;
    logic flag_rd = 1'b0;
    logic [4:0] flag_clr = 5'd0;
    logic [4:0] flags;
    logic irq;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    async_rx_fifo #(.DEPTH(DEPTH), .OVS(OVS), .IDLE_BITS(IDLE)) u_async_rx_fifo (
        .clk(clk), .rst(rst), .samp_en(samp_en), .rxd(rxd),
        .par_en(par_en), .par_odd(par_odd), .trig_lvl(trig_lvl), .ien(ien),
        .rd_pop(rd_pop), .rd_data(rd_data), .rd_ferr(rd_ferr), .rd_perr(rd_perr),
        .rd_valid(rd_valid), .fifo_count(fifo_count), .flag_rd(flag_rd),
        .flag_clr(flag_clr), .flags(flags), .irq(irq)
    );

    initial forever begin
        @(negedge clk);
        samp_en = ~samp_en;
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        rxd = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic hold_bit(input logic v);
        rxd = v;
        repeat (BITCLK) @(negedge clk);
    endtask

    task automatic idle_bits(input int n);
        rxd = 1'b1;
        repeat (n * BITCLK) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] b, input logic use_par,
                              input logic pval, input logic stopv);
        hold_bit(1'b0);
        for (int i = 0; i < 8; i++) hold_bit(b[i]);
        if (use_par) hold_bit(pval);
        hold_bit(stopv);
        idle_bits(1);
    endtask

    task automatic pop_entry(output logic [7:0] d, output logic fe, output logic pe);
        d = rd_data; fe = rd_ferr; pe = rd_perr;
        rd_pop = 1'b1;
        @(negedge clk);
        rd_pop = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_rd();
        flag_rd = 1'b1; @(negedge clk); flag_rd = 1'b0; @(negedge clk);
    endtask

    task automatic pulse_clr(input logic [4:0] m);
        flag_clr = m; @(negedge clk); flag_clr = 5'd0; @(negedge clk);
    endtask

    initial begin
        logic [7:0] d;
        logic fe, pe;
        logic [7:0] b;
        logic pv;

        do_reset();
        // R5 reset state
        check("R5", "count after reset", fifo_count, 0);
        check("R5", "valid after reset", rd_valid, 0);
        check("R12", "flags after reset", flags, 0);
        check("R12", "irq after reset", irq, 0);

        // R1 sweep every byte value, parity off
        for (int v = 0; v < 256; v++) begin
            send_frame(8'(v), 1'b0, 1'b0, 1'b1);
            check("R5", "valid after frame", rd_valid, 1);
            pop_entry(d, fe, pe);
            check("R1", "data", d, v);
            check("R1", "tags", {fe, pe}, 0);
        end
        check("R5", "count after sweep", fifo_count, 0);

        // R3 R4 parity both senses, good then bad
        par_en = 1'b1;
        for (int odd = 0; odd < 2; odd++) begin
            do_reset();
            par_odd = odd[0];
            for (int k = 0; k < 32; k++) begin
                b  = 8'((k * 37 + odd * 11) & 255);
                pv = (^b) ^ odd[0];
                send_frame(b, 1'b1, ~pv, 1'b1);
                send_frame(b ^ 8'h5a, 1'b1, (^(b ^ 8'h5a)) ^ odd[0], 1'b1);
                pop_entry(d, fe, pe);
                check("R3", "bad parity data", d, b);
                check("R3", "bad parity tags", {fe, pe}, 2'b01);
                pop_entry(d, fe, pe);
                check("R4", "next frame data", d, b ^ 8'h5a);
                check("R4", "next frame tags", {fe, pe}, 0);
            end
            check("R9", "error flag after parity errors", flags[1], 1);
        end
        par_en = 1'b0; par_odd = 1'b0;

        // R3 R4 R9 framing error
        do_reset();
        send_frame(8'ha5, 1'b0, 1'b0, 1'b0);
        check("R9", "error flag on framing error", flags[1], 1);
        check("R10", "no break on nonzero data", flags[2], 0);
        send_frame(8'h3c, 1'b0, 1'b0, 1'b1);
        check("R4", "count after error", fifo_count, 2);
        pop_entry(d, fe, pe);
        check("R3", "framing err entry", {d, fe, pe}, {8'ha5, 2'b10});
        pop_entry(d, fe, pe);
        check("R4", "entry after framing err", {d, fe, pe}, {8'h3c, 2'b00});

        // R2 glitch rejection
        do_reset();
        rxd = 1'b0; repeat (6) @(negedge clk); rxd = 1'b1;
        idle_bits(3);
        check("R2", "glitch stores nothing", fifo_count, 0);
        rxd = 1'b0; repeat (4) @(negedge clk); rxd = 1'b1;
        idle_bits(3);
        check("R2", "short glitch stores nothing", fifo_count, 0);
        send_frame(8'hc3, 1'b0, 1'b0, 1'b1);
        pop_entry(d, fe, pe);
        check("R2", "frame after glitch", {d, fe, pe}, {8'hc3, 2'b00});

        // R10 break
        do_reset();
        rxd = 1'b0; repeat (14 * BITCLK) @(negedge clk);
        idle_bits(3);
        check("R10", "one entry for break", fifo_count, 1);
        check("R10", "break flag", flags[2], 1);
        check("R9", "error flag on break", flags[1], 1);
        pop_entry(d, fe, pe);
        check("R10", "break entry", {d, fe, pe}, {8'h00, 2'b10});

        // R6 overrun
        do_reset();
        trig_lvl = CNTW'(DEPTH);
        for (int k = 0; k <= DEPTH; k++) send_frame(8'(8'h11 * (k + 1)), 1'b0, 1'b0, 1'b1);
        check("R6", "count at overrun", fifo_count, DEPTH);
        check("R6", "overrun flag", flags[4], 1);
        check("R7", "level flag at full", flags[0], 1);
        for (int k = 0; k < DEPTH; k++) begin
            pop_entry(d, fe, pe);
            check("R6", "kept entry", d, 8'h11 * (k + 1));
        end

        // R7 trigger levels 0..DEPTH
        for (int t = 0; t <= DEPTH; t++) begin
            do_reset();
            trig_lvl = CNTW'(t);
            for (int n = 1; n <= DEPTH; n++) begin
                send_frame(8'(n), 1'b0, 1'b0, 1'b1);
                check("R7", "level flag vs count", flags[0], (n >= ((t == 0) ? 1 : t)) ? 1 : 0);
            end
        end

        // R8 clear semantics
        do_reset();
        trig_lvl = CNTW'(2);
        send_frame(8'h01, 1'b0, 1'b0, 1'b1);
        send_frame(8'h02, 1'b0, 1'b0, 1'b1);
        pulse_clr(5'b00001);
        check("R8", "clear without read ignored", flags[0], 1);
        pulse_rd();
        pulse_clr(5'b00001);
        check("R8", "set wins over clear", flags[0], 1);
        pop_entry(d, fe, pe);
        pulse_clr(5'b00001);
        check("R8", "clear needs a new read", flags[0], 1);
        pulse_rd();
        pulse_clr(5'b00001);
        check("R8", "read then clear", flags[0], 0);

        // R11 data ready and R12 interrupt gating
        do_reset();
        trig_lvl = CNTW'(DEPTH);
        send_frame(8'h77, 1'b0, 1'b0, 1'b1);
        check("R11", "ready not before idle window", flags[3], 0);
        idle_bits(2);
        check("R11", "ready after idle window", flags[3], 1);
        ien = 4'b0000;
        @(negedge clk);
        check("R12", "irq masked", irq, 0);
        ien = 4'b1000;
        @(negedge clk);
        check("R12", "irq from ready", irq, 1);
        ien = 4'b0111;
        @(negedge clk);
        check("R12", "irq other enables only", irq, 0);
        ien = 4'b0000;

        do_reset();
        trig_lvl = CNTW'(1);
        send_frame(8'h55, 1'b0, 1'b0, 1'b1);
        idle_bits(3);
        check("R11", "no ready at trigger level", flags[3], 0);
        ien = 4'b0001;
        @(negedge clk);
        check("R12", "irq from level flag", irq, 1);
        ien = 4'b0000;

        // R12 overrun alone never interrupts
        do_reset();
        trig_lvl = CNTW'(0);
        for (int k = 0; k <= DEPTH; k++) send_frame(8'(k), 1'b0, 1'b0, 1'b1);
        pulse_rd();
        pulse_clr(5'b01111);
        ien = 4'b1111;
        @(negedge clk);
        check("R6", "overrun still set", flags[4], 1);
        check("R12", "overrun alone with level still set", irq, flags[0]);
        ien = 4'b0000;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule